// File: doc/BRIEF.md
# Sample-Rate Timing Select Divider

This block produces the timing strobes for a pair of sample-rate-converter channels. Each channel picks its timing from one of two families. The first family is five divided sources: three reference clocks and two baud-generator outputs. The selected source is divided by a ratio taken from a fixed, non-linear table. The second family is the word-select strobes of the serial audio ports, which pass through undivided. All source and word-select inputs are slow level signals. They are sampled into the block clock by a two-flop synchronizer, and each rising edge becomes a one-cycle tick.

Software configures the pair through one 32-bit select register shared by both channels. The even channel owns the lower half and the odd channel the upper half. A second register holds one enable bit per divided source. The outputs are plain one-cycle pulses, one per channel, in the block clock domain. No data stream crosses this block, so every pin is plain control and no valid/ready handshake exists.

Top module: `rate_timing_sel`

## Requirements
- R1: After reset both strobes are low, the select register reads as all zero and every divided-source enable is clear, so toggling a source produces no strobe until software writes.
- R2: A write with `wr_addr`=0 loads the select register. The even channel uses bits 11:8 as its source code and bits 4:0 as its ratio index. The odd channel uses bits 27:24 and 20:16 the same way. Every other bit of the write is ignored.
- R3: Source codes 0 to 4 choose `src_clk_i[0]` to `src_clk_i[4]` (reference A, reference B, reference C, generator A, generator B). Edges on unselected sources have no effect on the channel.
- R4: A divided channel emits one strobe for every N rising edges of its source, with N taken from the ratio index: 0→2, 1→4, 2→6, 3→8, 4→12, 5→16, and after that every even index 2k gives 3·2^k and every odd index 2k+1 gives 2^(k+2), up to index 28→49152.
- R5: Index 29 and the unused indices 30 and 31 all give the largest ratio, 98304.
- R6: A write with `wr_addr`=1 sets the enable of divided source n from bit n+1 of `wr_data`. While its source is disabled, a channel gives no strobe and its count stays at zero.
- R7: Source code 6+w forwards every rising edge of `ws_i[w]` as one strobe, without division. The strobe is high in the third clock cycle after the edge is presented.
- R8: When `pin_share` is high, word-select ports 1, 2 and 9 take port 0's strobe, port 4 takes port 3's, and port 8 takes port 7's. All other ports keep their own.
- R9: Source code 5 holds the channel's strobe low.
- R10: Every strobe is exactly one clock cycle wide.
- R11: A select write that changes a channel's field restarts that channel's count and discards any tick landing in the same cycle. A write that leaves a channel's field unchanged does not disturb that channel, even when a tick arrives in that cycle.
- R12: The two channels divide independently. When they use the same source and ratio, they pulse in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are produced in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_share | input | 1 | Selects the shared-pin word-select remapping |
| src_clk_i | input | 5 | Divided sources: reference A, B, C, generator A, B |
| ws_i | input | NUM_WS (10) | Word-select strobes of the serial audio ports |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = shared select register, 1 = divider enable register |
| wr_data | input | 32 | Register write data |
| strobe_o | output | 2 | Timing strobe per channel; bit 0 even, bit 1 odd |

## Verification
A select write and a source tick can reach a channel's counter in the same cycle. The bench provokes this by timing the write so that it is sampled at the same edge where the synchronized tick is consumed. It does this twice. In the first case the write changes only the even field, and the odd channel must still pulse on its second edge. In the second case the write changes the odd field, and that tick must be lost, so the next pulse comes only after a full new ratio of edges.

// File: rtl/rts_pkg.sv
package rts_pkg;

  localparam int NUM_DIV_SRC = 5;
  localparam int NUM_CH      = 2;
  localparam int SEL_W       = 4;
  localparam int IDX_W       = 5;
  localparam int WS_BASE     = 6;
  localparam int MAX_WS      = (1 << SEL_W) - WS_BASE;
  localparam int MAX_DIV     = 98304;
  localparam int SKIP_IDX    = 28;
  localparam int RATIO_W     = $clog2(MAX_DIV + 1);
  localparam int TBL_LEN     = 1 << IDX_W;
  localparam int FIELD_W     = 16;
  localparam logic [FIELD_W-1:0] FIELD_MASK = 16'h0F1F;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef ratio_t [TBL_LEN-1:0] ratio_tbl_t;

  typedef struct packed {
    logic [SEL_W-1:0] src;
    logic [IDX_W-1:0] idx;
  } chan_cfg_t;

  // Ratio table: step doubles after each odd index above 2; one entry is
  // skipped at SKIP_IDX. Unfilled indices saturate at MAX_DIV.
  function automatic ratio_tbl_t build_ratio_table();
    ratio_tbl_t  t;
    int unsigned div;
    int unsigned step;
    div  = 2;
    step = 2;
    for (int i = 0; i < TBL_LEN; i++) t[i] = RATIO_W'(MAX_DIV);
    for (int i = 0; i < TBL_LEN && div <= MAX_DIV; i++) begin
      t[i] = RATIO_W'(div);
      if (i > 2 && (i % 2) == 1) step = step * 2;
      if (i == SKIP_IDX) begin
        div  = div + step;
        step = step * 2;
      end
      div = div + step;
    end
    return t;
  endfunction

  // Word-select port whose strobe is used when pins are shared.
  function automatic int ws_shared_port(input int w);
    case (w)
      1, 2, 9: return 0;
      4:       return 3;
      8:       return 7;
      default: return w;
    endcase
  endfunction

  function automatic chan_cfg_t field_to_cfg(input logic [FIELD_W-1:0] f);
    chan_cfg_t c;
    c.src = f[11:8];
    c.idx = f[4:0];
    return c;
  endfunction

endpackage

// File: rtl/rts_sync_edge.sv
module rts_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] tick_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= lvl_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign tick_o = sync_q & ~last_q;

  // A synchronized rising edge lasts one cycle only (supports R10)
  assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    |tick_o |=> ((tick_o & $past(tick_o)) == '0));

endmodule

// File: rtl/rts_chan_div.sv
module rts_chan_div
  import rts_pkg::*;
#(
  parameter int NUM_WS = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  chan_cfg_t              cfg_i,
  input  logic                   restart_i,
  input  logic [NUM_DIV_SRC-1:0] div_tick_i,
  input  logic [NUM_DIV_SRC-1:0] div_en_i,
  input  logic [NUM_WS-1:0]      ws_tick_i,
  output logic                   strobe_o
);
  localparam ratio_tbl_t RATIOS = build_ratio_table();

  ratio_t cnt_q;
  ratio_t ratio;
  logic   strobe_q;
  logic   is_div;
  logic   is_ws;
  logic   src_on;
  logic   tick_sel;

  assign ratio = RATIOS[cfg_i.idx];

  always_comb begin
    is_div   = 1'b0;
    is_ws    = 1'b0;
    src_on   = 1'b0;
    tick_sel = 1'b0;
    for (int n = 0; n < NUM_DIV_SRC; n++) begin
      if (cfg_i.src == SEL_W'(n)) begin
        is_div   = 1'b1;
        src_on   = div_en_i[n];
        tick_sel = div_tick_i[n];
      end
    end
    for (int w = 0; w < NUM_WS; w++) begin
      if (cfg_i.src == SEL_W'(WS_BASE + w)) begin
        is_ws    = 1'b1;
        tick_sel = ws_tick_i[w];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (is_ws) begin
      cnt_q    <= '0;
      strobe_q <= tick_sel;
    end else if (is_div && src_on) begin
      if (tick_sel) begin
        if (cnt_q == ratio - RATIO_W'(1)) begin
          cnt_q    <= '0;
          strobe_q <= 1'b1;
        end else begin
          cnt_q    <= cnt_q + RATIO_W'(1);
          strobe_q <= 1'b0;
        end
      end else begin
        strobe_q <= 1'b0;
      end
    end else begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end
  end

  assign strobe_o = strobe_q;

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_div && !src_on) |=> (!strobe_q && cnt_q == '0));

  assert_code5_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.src == SEL_W'(5)) |=> !strobe_q);

  assert_ws_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ws && tick_sel && !restart_i) |=> strobe_q);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio);

endmodule

// File: rtl/rate_timing_sel.sv
module rate_timing_sel
  import rts_pkg::*;
#(
  parameter int NUM_WS = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pin_share,
  input  logic [NUM_DIV_SRC-1:0] src_clk_i,
  input  logic [NUM_WS-1:0]      ws_i,
  input  logic                   wr_en,
  input  logic                   wr_addr,
  input  logic [31:0]            wr_data,
  output logic [NUM_CH-1:0]      strobe_o
);
  localparam logic [31:0] SEL_MASK = {FIELD_MASK, FIELD_MASK};

  logic [31:0]            sel_q;
  logic [NUM_DIV_SRC-1:0] en_q;
  logic [NUM_DIV_SRC-1:0] div_tick;
  logic [NUM_WS-1:0]      ws_tick;
  logic [NUM_WS-1:0]      ws_tick_eff;
  logic                   sel_wr;

  assign sel_wr = wr_en && !wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
    end else if (wr_en) begin
      if (!wr_addr) sel_q <= wr_data & SEL_MASK;
      else          en_q  <= wr_data[NUM_DIV_SRC:1];
    end
  end

  rts_sync_edge #(.W(NUM_DIV_SRC)) u_src_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (src_clk_i),
    .tick_o (div_tick)
  );

  rts_sync_edge #(.W(NUM_WS)) u_ws_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (ws_i),
    .tick_o (ws_tick)
  );

  for (genvar w = 0; w < NUM_WS; w++) begin : g_ws_map
    localparam int SHARED = ws_shared_port(w);
    assign ws_tick_eff[w] = pin_share ? ws_tick[SHARED] : ws_tick[w];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    chan_cfg_t cur_cfg;
    chan_cfg_t new_cfg;
    logic      restart;

    assign cur_cfg = field_to_cfg(sel_q[c*FIELD_W +: FIELD_W]);
    assign new_cfg = field_to_cfg(wr_data[c*FIELD_W +: FIELD_W]);
    assign restart = sel_wr && (new_cfg != cur_cfg);

    rts_chan_div #(.NUM_WS(NUM_WS)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_i      (cur_cfg),
      .restart_i  (restart),
      .div_tick_i (div_tick),
      .div_en_i   (en_q),
      .ws_tick_i  (ws_tick_eff),
      .strobe_o   (strobe_o[c])
    );
  end

  // A write changing the even field discards that cycle's even strobe
  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && ((wr_data[15:0] & FIELD_MASK) != sel_q[15:0])) |=> !strobe_o[0]);

  // Enables stay clear until software writes the enable register
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && sel_q == '0) |=> !strobe_o[0]);

endmodule

// File: tb/rate_timing_sel_tb_top.sv
module rate_timing_sel_tb_top;
  localparam int NUM_WS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_share = 1'b0;
  logic [4:0]  src = '0;
  logic [NUM_WS-1:0] ws = '0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  strobe;

  int checks = 0;
  int fails = 0;
  int pc0 = 0;
  int pc1 = 0;
  int both = 0;
  int dbl = 0;
  logic [1:0] prev_s = '0;

  always #5 clk = ~clk;

  rate_timing_sel #(.NUM_WS(NUM_WS)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_share (pin_share),
    .src_clk_i (src),
    .ws_i      (ws),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .strobe_o  (strobe)
  );

  always @(negedge clk) begin
    if (strobe[0]) pc0++;
    if (strobe[1]) pc1++;
    if (strobe == 2'b11) both++;
    if ((strobe & prev_s) != 2'b00) dbl++;
    prev_s = strobe;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fld(input int s, input int idx);
    return 16'((s << 8) | idx);
  endfunction

  task automatic reg_wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic src_edges(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src[k] = 1'b1;
      @(negedge clk); src[k] = 1'b0;
    end
    settle();
  endtask

  task automatic ws_edges(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ws[k] = 1'b1;
      @(negedge clk); ws[k] = 1'b0;
    end
    settle();
  endtask

  task automatic t_reset();
    int b0, b1;
    check("R1 strobe after reset", int'(strobe), 0);
    b0 = pc0; b1 = pc1;
    src_edges(0, 6);
    src_edges(3, 6);
    check("R1 even quiet before config", pc0 - b0, 0);
    check("R1 odd quiet before config", pc1 - b1, 0);
  endtask

  task automatic t_basic();
    int b0, b1;
    reg_wr(1'b1, 32'h3E);
    reg_wr(1'b0, {fld(4, 3), fld(0, 0)});
    b0 = pc0; b1 = pc1;
    src_edges(0, 10);
    check("R4 ratio 2 on ref A", pc0 - b0, 5);
    b0 = pc0;
    src_edges(1, 8);
    check("R3 unselected source ignored", pc0 - b0, 0);
    src_edges(4, 16);
    check("R3 R4 ratio 8 on generator B", pc1 - b1, 2);
  endtask

  task automatic t_steps();
    int b0, b1;
    reg_wr(1'b0, {fld(2, 4), fld(1, 5)});
    b0 = pc0; b1 = pc1;
    src_edges(1, 31);
    check("R4 ratio 16 one short", pc0 - b0, 1);
    src_edges(1, 1);
    check("R4 ratio 16 on ref B", pc0 - b0, 2);
    src_edges(2, 24);
    check("R4 ratio 12 on ref C", pc1 - b1, 2);
    reg_wr(1'b0, {fld(3, 2), fld(0, 7)});
    b0 = pc0; b1 = pc1;
    src_edges(0, 64);
    src_edges(3, 12);
    check("R4 ratio 32", pc0 - b0, 2);
    check("R4 ratio 6 on generator A", pc1 - b1, 2);
  endtask

  task automatic t_mask();
    int b0, b1;
    reg_wr(1'b0, 32'hF3E0_F0E1);
    b0 = pc0; b1 = pc1;
    src_edges(0, 8);
    check("R2 even field ratio 4, junk bits ignored", pc0 - b0, 2);
    check("R2 odd not on ref A", pc1 - b1, 0);
    src_edges(3, 4);
    check("R2 odd field from bits 27:24/20:16", pc1 - b1, 2);
  endtask

  task automatic t_enable();
    int b0, b1;
    reg_wr(1'b0, {fld(1, 0), fld(0, 0)});
    reg_wr(1'b1, 32'h3C);
    b0 = pc0; b1 = pc1;
    src_edges(0, 6);
    check("R6 disabled source quiet", pc0 - b0, 0);
    src_edges(1, 4);
    check("R6 other source still enabled", pc1 - b1, 2);
    reg_wr(1'b1, 32'h3E);
    b0 = pc0;
    src_edges(0, 3);
    check("R6 count held at zero while disabled", pc0 - b0, 1);
  endtask

  task automatic t_ws();
    int b0, b1;
    pin_share = 1'b0;
    reg_wr(1'b0, {fld(6 + 2, 0), fld(6 + 5, 9)});
    @(negedge clk); ws[5] = 1'b1;
    @(negedge clk); ws[5] = 1'b0;
    check("R7 latency cycle 1", int'(strobe[0]), 0);
    @(negedge clk);
    check("R7 latency cycle 2", int'(strobe[0]), 0);
    @(negedge clk);
    check("R7 strobe on cycle 3", int'(strobe[0]), 1);
    @(negedge clk);
    check("R7 strobe falls", int'(strobe[0]), 0);
    settle();
    b0 = pc0; b1 = pc1;
    ws_edges(5, 5);
    check("R7 undivided passthrough", pc0 - b0, 5);
    ws_edges(2, 3);
    check("R7 odd on port 2", pc1 - b1, 3);
  endtask

  task automatic t_share();
    int b0, b1;
    pin_share = 1'b1;
    reg_wr(1'b0, {fld(6 + 8, 0), fld(6 + 2, 0)});
    b0 = pc0; b1 = pc1;
    ws_edges(2, 3);
    check("R8 port 2 own pin ignored", pc0 - b0, 0);
    ws_edges(0, 2);
    check("R8 port 2 uses port 0", pc0 - b0, 2);
    ws_edges(8, 2);
    check("R8 port 8 own pin ignored", pc1 - b1, 0);
    ws_edges(7, 2);
    check("R8 port 8 uses port 7", pc1 - b1, 2);
    reg_wr(1'b0, {fld(6 + 8, 0), fld(6 + 4, 0)});
    b0 = pc0;
    ws_edges(3, 2);
    check("R8 port 4 uses port 3", pc0 - b0, 2);
    pin_share = 1'b0;
  endtask

  task automatic t_code5();
    int b0;
    reg_wr(1'b0, {fld(6 + 8, 0), fld(5, 0)});
    b0 = pc0;
    for (int k = 0; k < 5; k++) src_edges(k, 2);
    for (int k = 0; k < NUM_WS; k++) ws_edges(k, 1);
    check("R9 code 5 quiet", pc0 - b0, 0);
  endtask

  task automatic t_restart();
    int b0, b1;
    reg_wr(1'b0, {fld(1, 0), fld(0, 0)});
    b0 = pc0;
    src_edges(0, 1);
    reg_wr(1'b0, {fld(1, 0), fld(0, 1)});
    src_edges(0, 3);
    check("R11 changed field restarts count", pc0 - b0, 0);
    src_edges(0, 1);
    check("R11 pulse after full new ratio", pc0 - b0, 1);
    // odd: first edge, then second edge coincident with an even-only write
    b1 = pc1;
    src_edges(1, 1);
    @(negedge clk); src[1] = 1'b1;
    @(negedge clk); src[1] = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wr_data = {fld(1, 0), fld(0, 0)};
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    settle();
    check("R11 unchanged odd field keeps tick", pc1 - b1, 1);
    // odd: coincident write that changes odd field drops the tick
    b1 = pc1;
    src_edges(1, 1);
    @(negedge clk); src[1] = 1'b1;
    @(negedge clk); src[1] = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wr_data = {fld(1, 1), fld(0, 0)};
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    settle();
    check("R11 changed odd field drops tick", pc1 - b1, 0);
    src_edges(1, 3);
    check("R11 odd restarted at zero", pc1 - b1, 0);
    src_edges(1, 1);
    check("R11 odd pulse at fourth edge", pc1 - b1, 1);
  endtask

  task automatic t_parallel();
    int b0, b1, bb;
    reg_wr(1'b0, {fld(0, 0), fld(0, 0)});
    b0 = pc0; b1 = pc1; bb = both;
    src_edges(0, 4);
    check("R12 even count", pc0 - b0, 2);
    check("R12 odd count", pc1 - b1, 2);
    check("R12 same-cycle pulses", both - bb, 2);
  endtask

  task automatic t_big();
    int b0, b1;
    reg_wr(1'b0, {fld(0, 31), fld(0, 28)});
    b0 = pc0; b1 = pc1;
    src_edges(0, 49151);
    check("R4 ratio 49152 one short", pc0 - b0, 0);
    src_edges(0, 1);
    check("R4 ratio 49152 at index 28", pc0 - b0, 1);
    check("R5 index 31 beyond 49152", pc1 - b1, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_steps();
    t_mask();
    t_enable();
    t_ws();
    t_share();
    t_code5();
    t_restart();
    t_parallel();
    t_big();
    check("R10 no strobe wider than one cycle", dbl, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule